// File: doc/BRIEF.md
# Memory-Mapped Processor Status Register

This block holds the status flags of a small 8-bit memory-to-memory processor: negative, zero, overflow, carry and a latched hardware-interrupt flag. On each clock edge it decides how these flags change. The ALU supplies four candidate flag values and the code of the ALU function it is running. A decoder turns that function code into a per-flag write mask, so only the flags that belong to that operation are updated. All other flags keep their value.

The register also appears at one fixed data address (0xC8 by default). A store to that address replaces the flags, so programs can set, clear and mask individual flags with ordinary memory instructions. A load from that address returns them. A hardware interrupt request sets the interrupt flag, which then stays set until reset or until a store clears it. The block only arbitrates among these three sources. Flag equations, instruction decode and the memory array are outside it.

Top module: `psw_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every stored flag to 0, so a read at the mapped address returns 0x00 afterwards.
- R2: The flags read back at the mapped address (default 0xC8) use this layout: N in bit 0, Z in bit 1, V in bit 2, C in bit 3, I in bit 4. The read data is combinational from the stored flags.
- R3: `bus_rdata` is 0x00 whenever `bus_addr` differs from the mapped address.
- R4: The ALU function code selects which flags take the value of `alu_nzvc` (bit 0 N, bit 1 Z, bit 2 V, bit 3 C) at the next edge, as follows:
  - NZVC: codes 1 (add), 4 (invert B), 10 (increment), 11 (decrement), 12 (subtract) and 13 (compare).
  - NZV: codes 5 (and) and 6 (or).
  - NZ: codes 2 (pass A), 3 (pass B), 7 (zero), 8 (minus one) and 9 (one).
- R5: A flag that the current function code does not enable keeps its stored value.
- R6: With `bus_we` high and `bus_addr` equal to the mapped address, the flags take `bus_wdata[4:0]` at the next edge.
- R7: A mapped bus write takes priority over an ALU flag update in the same cycle.
- R8: A bus write with `bus_we` low, or to any address other than the mapped one, leaves the flags unchanged.
- R9: Bits 7 to 5 always read as zero, and bus writes to them have no effect.
- R10: `irq` high at an edge sets I. I then stays set after `irq` falls, and ALU updates never change it.
- R11: A mapped bus write with bit 4 low clears I. If that write comes in the same cycle as `irq`, the bus value wins.
- R12: Function codes 0 (no operation), 14 and 15 update no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alu_fn | input | 4 | ALU function code of the current cycle |
| alu_nzvc | input | 4 | Candidate flags from the ALU: N, Z, V, C in bits 0 to 3 |
| irq | input | 1 | Hardware interrupt request |
| bus_addr | input | 8 | Data address of the current bus cycle |
| bus_wdata | input | 8 | Store data |
| bus_we | input | 1 | Store strobe |
| bus_rdata | output | 8 | Flags when the address matches, else zero |
| psw_o | output | 8 | Stored flags, bits 7 to 5 zero |

## Verification
The checker assumes that `bus_addr`, `bus_we`, `alu_fn` and `irq` are settled and free of X at every rising edge. It also assumes that reset is held high from time zero through at least one edge. Its rules for "no change" assume a quiet cycle: no mapped write, no interrupt request, and a function code of 0, 14 or 15.

The bench keeps within these assumptions. It asserts reset first and drives all inputs on the falling edge. It returns every input to that quiet state right after each active edge. It reads the flags at the mapped address with the write strobe low, so a read never doubles as a store.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int FN_W   = 4;
    localparam int FLAG_N = 4;

    typedef enum logic [FN_W-1:0] {
        FN_NOP   = 4'd0,
        FN_ADD   = 4'd1,
        FN_PASSA = 4'd2,
        FN_PASSB = 4'd3,
        FN_NOTB  = 4'd4,
        FN_AND   = 4'd5,
        FN_OR    = 4'd6,
        FN_ZERO  = 4'd7,
        FN_MONE  = 4'd8,
        FN_ONE   = 4'd9,
        FN_INC   = 4'd10,
        FN_DEC   = 4'd11,
        FN_SUB   = 4'd12,
        FN_CMP   = 4'd13,
        FN_RES14 = 4'd14,
        FN_RES15 = 4'd15
    } alu_fn_e;

    // Bit 0 is N, bit 4 is I.
    typedef struct packed {
        logic i;
        logic c;
        logic v;
        logic z;
        logic n;
    } flags_t;

    localparam logic [FLAG_N-1:0] MASK_NZVC = 4'b1111;
    localparam logic [FLAG_N-1:0] MASK_NZV  = 4'b0111;
    localparam logic [FLAG_N-1:0] MASK_NZ   = 4'b0011;
    localparam logic [FLAG_N-1:0] MASK_NONE = 4'b0000;

endpackage

// File: rtl/psw_fn_decode.sv
module psw_fn_decode
    import psw_pkg::*;
(
    input  logic [FN_W-1:0]   fn,
    output logic [FLAG_N-1:0] wr_mask
);
    alu_fn_e fn_e;
    assign fn_e = alu_fn_e'(fn);

    always_comb begin
        unique case (fn_e)
            FN_ADD, FN_NOTB, FN_INC, FN_DEC, FN_SUB, FN_CMP:
                wr_mask = MASK_NZVC;
            FN_AND, FN_OR:
                wr_mask = MASK_NZV;
            FN_PASSA, FN_PASSB, FN_ZERO, FN_MONE, FN_ONE:
                wr_mask = MASK_NZ;
            default:
                wr_mask = MASK_NONE;
        endcase
    end
endmodule

// File: rtl/psw_addr_match.sv
module psw_addr_match #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] MAP_ADDR = 8'hC8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              rd_sel,
    output logic              wr_sel
);
    always_comb begin
        rd_sel = (addr == MAP_ADDR);
        wr_sel = rd_sel && we;
    end
endmodule

// File: rtl/psw_reg.sv
module psw_reg
    import psw_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] PSW_ADDR = 8'hC8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FN_W-1:0]   alu_fn,
    input  logic [FLAG_N-1:0] alu_nzvc,
    input  logic              irq,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] psw_o
);
    localparam int ST_W  = $bits(flags_t);
    localparam int PAD_W = DATA_W - ST_W;

    typedef struct packed {
        flags_t flags;
    } state_t;

    state_t            st_d, st_q;
    logic [FLAG_N-1:0] wr_mask;
    logic              rd_sel, wr_sel;
    logic [ST_W-1:0]   flat_q;

    psw_fn_decode u_dec (
        .fn      (alu_fn),
        .wr_mask (wr_mask)
    );

    psw_addr_match #(
        .ADDR_W   (ADDR_W),
        .MAP_ADDR (PSW_ADDR)
    ) u_match (
        .addr   (bus_addr),
        .we     (bus_we),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    always_comb begin
        logic [ST_W-1:0] nxt;
        nxt = st_q.flags;
        if (wr_sel) begin
            nxt = bus_wdata[ST_W-1:0];
        end else begin
            for (int k = 0; k < FLAG_N; k++) begin
                if (wr_mask[k]) nxt[k] = alu_nzvc[k];
            end
            if (irq) nxt[ST_W-1] = 1'b1;
        end
        st_d.flags = flags_t'(nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flat_q = st_q.flags;

    generate
        if (PAD_W > 0) begin : g_pad
            assign psw_o = {{PAD_W{1'b0}}, flat_q};
        end else begin : g_nopad
            assign psw_o = flat_q[DATA_W-1:0];
        end
    endgenerate

    assign bus_rdata = rd_sel ? psw_o : '0;

endmodule

// File: rtl/psw_reg_chk.sv
module psw_reg_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] PSW_ADDR = 8'hC8
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        alu_fn,
    input logic              irq,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] psw_o
);
    logic hit_wr, quiet;
    assign hit_wr = bus_we && (bus_addr == PSW_ADDR);
    assign quiet  = !hit_wr && !irq &&
                    (alu_fn == 4'd0 || alu_fn == 4'd14 || alu_fn == 4'd15);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (psw_o == '0)); // R1

    AST_READ_MAPPED: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == PSW_ADDR) |-> (bus_rdata == psw_o)); // R2

    AST_READ_OTHER: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != PSW_ADDR) |-> (bus_rdata == '0)); // R3

    AST_BUS_WINS: assert property (@(posedge clk) disable iff (rst)
        hit_wr |=> (psw_o[4:0] == $past(bus_wdata[4:0]))); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        psw_o[DATA_W-1:5] == '0); // R9

    AST_IRQ_SETS: assert property (@(posedge clk) disable iff (rst)
        (irq && !hit_wr) |=> psw_o[4]); // R10

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (psw_o[4] && !hit_wr) |=> psw_o[4]); // R10

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        quiet |=> $stable(psw_o)); // R12

endmodule

bind psw_reg psw_reg_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PSW_ADDR (PSW_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .alu_fn    (alu_fn),
    .irq       (irq),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .psw_o     (psw_o)
);

// File: tb/sim_psw_reg.sv
module sim_psw_reg;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] MAP        = 8'hC8;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] alu_fn;
    logic [3:0] alu_nzvc;
    logic       irq;
    logic [7:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_we;
    logic [7:0] bus_rdata;
    logic [7:0] psw_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psw_reg u0 (
        .clk       (clk),
        .rst       (rst),
        .alu_fn    (alu_fn),
        .alu_nzvc  (alu_nzvc),
        .irq       (irq),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .psw_o     (psw_o)
    );

    function automatic logic [3:0] spec_mask(input int fn);
        case (fn)
            1, 4, 10, 11, 12, 13:  return 4'b1111;
            5, 6:                  return 4'b0111;
            2, 3, 7, 8, 9:         return 4'b0011;
            default:               return 4'b0000;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_fn = 4'd0; alu_nzvc = 4'd0; irq = 1'b0;
        bus_we = 1'b0; bus_addr = MAP; bus_wdata = 8'h00;
    endtask

    // One active edge with the given stimulus, then back to a quiet read.
    task automatic cycle(input logic [3:0] fn, input logic [3:0] nzvc, input logic rq,
                         input logic we, input logic [7:0] addr, input logic [7:0] wd);
        @(negedge clk);
        alu_fn = fn; alu_nzvc = nzvc; irq = rq;
        bus_we = we; bus_addr = addr; bus_wdata = wd;
        @(posedge clk);
        #1 idle();
        #1;
    endtask

    task automatic store(input logic [7:0] wd);
        cycle(4'd0, 4'd0, 1'b0, 1'b1, MAP, wd);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1; idle();
        @(posedge clk); @(posedge clk);
        #2 check("R1 reset state", bus_rdata, 8'h00);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_store_and_layout();
        store(8'h15);
        check("R2 layout read 0x15", bus_rdata, 8'h15);
        check("R6 store value on psw_o", psw_o, 8'h15);
        store(8'hFF);
        check("R9 upper bits read zero", bus_rdata, 8'h1F);
        store(8'hE0);
        check("R9 upper-only store", bus_rdata, 8'h00);
        store(8'h0A);
        check("R6 store 0x0A", bus_rdata, 8'h0A);
    endtask

    task automatic t_other_addr();
        store(8'h0F);
        bus_addr = 8'hC7; #1 check("R3 read 0xC7", bus_rdata, 8'h00);
        bus_addr = 8'hC9; #1 check("R3 read 0xC9", bus_rdata, 8'h00);
        bus_addr = 8'h00; #1 check("R3 read 0x00", bus_rdata, 8'h00);
        bus_addr = MAP;   #1;
    endtask

    task automatic t_ignored_writes();
        store(8'h05);
        cycle(4'd0, 4'd0, 1'b0, 1'b1, 8'hC7, 8'h1A);
        check("R8 store to other address", bus_rdata, 8'h05);
        cycle(4'd0, 4'd0, 1'b0, 1'b1, 8'h48, 8'h1A);
        check("R8 store to 0x48", bus_rdata, 8'h05);
        cycle(4'd0, 4'd0, 1'b0, 1'b0, MAP, 8'h1A);
        check("R8 strobe low", bus_rdata, 8'h05);
    endtask

    task automatic t_alu_masks();
        for (int f = 0; f < 16; f++) begin
            logic [3:0] m;
            m = spec_mask(f);
            store(8'h00);
            cycle(4'(f), 4'hF, 1'b0, 1'b0, MAP, 8'h00);
            check($sformatf("R4 fn %0d sets enabled", f), bus_rdata, {4'h0, m});
            store(8'h0F);
            cycle(4'(f), 4'h0, 1'b0, 1'b0, MAP, 8'h00);
            check($sformatf("R5 fn %0d holds others", f), bus_rdata, {4'h0, ~m});
            if (m == 4'b0000)
                check($sformatf("R12 fn %0d no update", f), bus_rdata, 8'h0F);
        end
        store(8'h00);
        cycle(4'd1, 4'b0101, 1'b0, 1'b0, MAP, 8'h00);
        check("R4 add mixed pattern", bus_rdata, 8'h05);
        cycle(4'd5, 4'b1010, 1'b0, 1'b0, MAP, 8'h00);
        check("R5 and keeps C", bus_rdata, 8'h02);
    endtask

    task automatic t_priority();
        store(8'h00);
        cycle(4'd1, 4'b0101, 1'b0, 1'b1, MAP, 8'h0A);
        check("R7 store beats add", bus_rdata, 8'h0A);
        cycle(4'd8, 4'b0011, 1'b0, 1'b1, MAP, 8'h04);
        check("R7 store beats minus-one", bus_rdata, 8'h04);
    endtask

    task automatic t_irq();
        store(8'h00);
        cycle(4'd0, 4'd0, 1'b1, 1'b0, MAP, 8'h00);
        check("R10 irq sets I", bus_rdata, 8'h10);
        cycle(4'd1, 4'hF, 1'b0, 1'b0, MAP, 8'h00);
        check("R10 I sticky over add", bus_rdata, 8'h1F);
        cycle(4'd7, 4'b0010, 1'b0, 1'b0, MAP, 8'h00);
        check("R10 I sticky over zero", bus_rdata, 8'h1E);
        store(8'h03);
        check("R11 store clears I", bus_rdata, 8'h03);
        cycle(4'd0, 4'd0, 1'b1, 1'b1, MAP, 8'h01);
        check("R11 store beats irq", bus_rdata, 8'h01);
        cycle(4'd0, 4'd0, 1'b1, 1'b1, 8'h10, 8'h00);
        check("R10 irq with foreign store", bus_rdata, 8'h11);
    endtask

    task automatic t_mid_reset();
        store(8'h1F);
        @(negedge clk); rst = 1'b1;
        @(posedge clk);
        #2 check("R1 reset mid-run", bus_rdata, 8'h00);
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        idle();
        t_reset();
        t_store_and_layout();
        t_other_addr();
        t_ignored_writes();
        t_alu_masks();
        t_priority();
        t_irq();
        t_mid_reset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule